// File: doc/BRIEF.md
# MAC Address Hash Filter Table

This block decides whether a 48-bit destination MAC address belongs to a station's accepted set. It keeps a 2048-entry open-addressed hash table in internal RAM. Each address is hashed to an 11-bit start slot. A single probe engine then walks consecutive slots, wrapping from the top index to zero, until it finds the address, finds an empty slot or uses up a fixed hop budget. Each entry holds the address in a packed key form and three flag bits: valid, skip and receive-destination.

Two request ports share the engine. The command port inserts, deletes, looks up or clears the whole table. The frame port presents destination addresses from the receive path and gets back hit, skip and receive-destination. Only one request is processed at a time. When both ports request in the same cycle, the command port wins.

The controller is a four-state machine:
- CLEAR sweeps every slot to zero. It is entered at reset and on a clear command, and returns to IDLE after the last slot.
- IDLE accepts a request. It moves to CLEAR for a clear command and to READ otherwise.
- READ fetches the current slot.
- EVAL decides on that slot. It either finishes and returns to IDLE, or steps to the next slot and returns to READ.

Top module: `mac_hash_filter`

## Requirements
- R1: After reset is released the table is swept empty. `cmd_ready` and `frm_ready` stay low for exactly 2048 cycles and then rise. This sweep produces no done pulse.
- R2: The start slot is computed as follows. H is the first two address bytes and L is the last four, each byte with its bit order reversed. Define a0 = L[7:2], a1 = {L[14:8], L[1:0]}, a2 = L[23:15] and a3 = {H[0], L[31:24]}. The slot is the low 11 bits of {a0, a1^a2^a3}. Addresses with equal slots collide and probe onward.
- R3: Probing visits the start slot and then the following slots, one per step, wrapping from 0x7FF to 0. It visits at most HOPS slots (default 12).
- R4: Insert (`cmd_op`=0) stops at the first empty slot or at the slot already holding the same address. It writes the address there with the given skip and receive-destination flags and returns status OK (0). Reinserting an existing address updates its flags in place.
- R5: When insert finds neither an empty slot nor the address within HOPS slots, it returns status FULL (1) and leaves the table unchanged.
- R6: Delete (`cmd_op`=1) empties the slot that holds the address. Delete returns OK (0) whether or not the address was present. An absent address leaves the table unchanged.
- R7: Lookup (`cmd_op`=2) returns HIT (2) with the stored skip and receive-destination flags. It returns MISS (3) with both flags 0 when it reaches an empty slot or exhausts HOPS slots.
- R8: The frame port performs a lookup and reports it on `frm_done`, `frm_hit`, `frm_skip` and `frm_rd`. While `cmd_valid` is high, `frm_ready` is low, so a command is always taken before a pending frame lookup.
- R9: Clear (`cmd_op`=3) empties all 2048 slots and returns OK. Its done pulse comes 2048 cycles after the accept edge.
- R10: A request is taken on a clock edge where valid and ready are both high, and ready then stays low until the request completes. A lookup, insert or delete that visits p slots raises its one-cycle done pulse 2p cycles after the accept edge. Done appears only on the port that made the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 0 insert, 1 delete, 2 lookup, 3 clear |
| cmd_mac | input | 48 | Command address, first byte in bits 47:40 |
| cmd_skip | input | 1 | Skip flag stored by insert |
| cmd_rd | input | 1 | Receive-destination flag stored by insert |
| cmd_done | output | 1 | One-cycle command completion |
| cmd_status | output | 2 | 0 OK, 1 FULL, 2 HIT, 3 MISS |
| cmd_hit_skip | output | 1 | Skip flag of a command lookup hit |
| cmd_hit_rd | output | 1 | Receive-destination flag of a command lookup hit |
| frm_valid | input | 1 | Frame lookup request |
| frm_ready | output | 1 | Frame lookup can be taken |
| frm_mac | input | 48 | Frame destination address |
| frm_done | output | 1 | One-cycle frame lookup completion |
| frm_hit | output | 1 | Frame address found |
| frm_skip | output | 1 | Skip flag of the found entry |
| frm_rd | output | 1 | Receive-destination flag of the found entry |

## Verification
The bench builds a bucket of thirteen colliding addresses and fills it. It then checks that the twelfth insert still succeeds, that the thirteenth reports FULL after exactly twelve probes, and that a lookup of the rejected address misses. An off-by-one hop limit would shift both the status and the latency. The bench also places three addresses on slot 0x7FF and looks up the last of them. A design that failed to wrap would miss that address or probe outside the table. Other cases cover flag overwrite on reinsert, delete of an absent address, and the hole a delete leaves in a chain, where a later entry becomes unreachable. A simultaneous command and frame request checks that the frame waits until the command has completed.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam int MAC_W  = 48;
    localparam int IDX_W  = 11;
    localparam int WORD_W = 32;
    localparam int F_VALID = 0;
    localparam int F_SKIP  = 1;
    localparam int F_RD    = 2;

    typedef enum logic [1:0] {
        OP_INSERT = 2'd0,
        OP_DELETE = 2'd1,
        OP_LOOKUP = 2'd2,
        OP_CLEAR  = 2'd3
    } mhf_op_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_FULL = 2'd1,
        ST_HIT  = 2'd2,
        ST_MISS = 2'd3
    } mhf_status_e;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } mhf_entry_t;

    function automatic logic [7:0] mirror8(input logic [7:0] b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = b[7-k];
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] slot_of(input logic [MAC_W-1:0] mac);
        logic [15:0] h;
        logic [31:0] l;
        logic [8:0]  fold;
        logic [14:0] wide;
        h = {mirror8(mac[47:40]), mirror8(mac[39:32])};
        l = {mirror8(mac[31:24]), mirror8(mac[23:16]),
             mirror8(mac[15:8]),  mirror8(mac[7:0])};
        fold = {l[14:8], l[1:0]} ^ l[23:15] ^ {h[0], l[31:24]};
        wide = {l[7:2], fold};
        return wide[IDX_W-1:0];
    endfunction

    function automatic mhf_entry_t key_of(input logic [MAC_W-1:0] mac);
        mhf_entry_t e;
        logic [15:0] hp;
        logic [31:0] lp;
        hp = mac[47:32];
        lp = mac[31:0];
        e.lo = {lp[20], lp[19:16], lp[31:28], lp[27:24],
                hp[7:4], hp[3:0], hp[15:12], hp[11:8], 3'b000};
        e.hi = {13'd0, lp[7:4], lp[3:0], lp[15:12], lp[11:8], lp[23:21]};
        return e;
    endfunction
endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
    import mhf_pkg::*;
(
    input  logic [MAC_W-1:0] mac,
    output logic [IDX_W-1:0] slot,
    output mhf_entry_t       key
);
    always_comb begin
        slot = slot_of(mac);
        key  = key_of(mac);
    end
endmodule

// File: rtl/mhf_ram.sv
module mhf_ram #(
    parameter int AW = 11,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter
    import mhf_pkg::*;
#(
    parameter int HOPS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_op,
    input  logic [47:0] cmd_mac,
    input  logic        cmd_skip,
    input  logic        cmd_rd,
    output logic        cmd_done,
    output logic [1:0]  cmd_status,
    output logic        cmd_hit_skip,
    output logic        cmd_hit_rd,
    input  logic        frm_valid,
    output logic        frm_ready,
    input  logic [47:0] frm_mac,
    output logic        frm_done,
    output logic        frm_hit,
    output logic        frm_skip,
    output logic        frm_rd
);
    localparam int DEPTH   = 1 << IDX_W;
    localparam int HOP_W   = $clog2(HOPS + 1);
    localparam int ENTRY_W = 2 * WORD_W;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);
    localparam logic [HOP_W-1:0] LAST_HOP  = HOP_W'(HOPS - 1);

    typedef enum logic [1:0] {S_CLEAR, S_IDLE, S_READ, S_EVAL} state_e;

    state_e      state_q, state_d;
    mhf_op_e     op_q;
    logic        from_frm_q;
    logic        clear_cmd_q;
    mhf_entry_t  key_q;
    logic        skip_q, rd_q;
    logic [IDX_W-1:0] idx_q, sweep_q;
    logic [HOP_W-1:0] hop_q;

    logic [MAC_W-1:0] in_mac;
    logic [IDX_W-1:0] in_slot;
    mhf_entry_t       in_key;
    logic             take_cmd, take_frm;

    logic [ENTRY_W-1:0] rd_word;
    mhf_entry_t         cur;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_addr;
    mhf_entry_t         wr_data;

    logic        finish, fin_hit, step;
    mhf_status_e fin_status;
    logic        slot_used, slot_same;

    assign cmd_ready = (state_q == S_IDLE);
    assign frm_ready = (state_q == S_IDLE) && !cmd_valid;
    assign take_cmd  = cmd_valid && cmd_ready;
    assign take_frm  = frm_valid && frm_ready;
    assign in_mac    = cmd_valid ? cmd_mac : frm_mac;

    mhf_hash u_hash (
        .mac  (in_mac),
        .slot (in_slot),
        .key  (in_key)
    );

    mhf_ram #(.AW(IDX_W), .DW(ENTRY_W)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (idx_q),
        .rdata (rd_word)
    );

    assign cur       = rd_word;
    assign slot_used = cur.lo[F_VALID];
    assign slot_same = slot_used && (cur.lo[WORD_W-1:3] == key_q.lo[WORD_W-1:3])
                       && (cur.hi == key_q.hi);

    always_comb begin
        state_d    = state_q;
        finish     = 1'b0;
        fin_hit    = 1'b0;
        fin_status = ST_OK;
        step       = 1'b0;
        wr_en      = 1'b0;
        wr_addr    = idx_q;
        wr_data    = '0;
        unique case (state_q)
            S_CLEAR: begin
                wr_en   = 1'b1;
                wr_addr = sweep_q;
                if (sweep_q == LAST_SLOT) begin
                    state_d = S_IDLE;
                    finish  = clear_cmd_q;
                end
            end
            S_IDLE: begin
                if (take_cmd && mhf_op_e'(cmd_op) == OP_CLEAR) state_d = S_CLEAR;
                else if (take_cmd || take_frm)                 state_d = S_READ;
            end
            S_READ: state_d = S_EVAL;
            S_EVAL: begin
                if (!slot_used || slot_same) begin
                    state_d = S_IDLE;
                    finish  = 1'b1;
                    unique case (op_q)
                        OP_INSERT: begin
                            wr_en   = 1'b1;
                            wr_data = key_q;
                            wr_data.lo[F_VALID] = 1'b1;
                            wr_data.lo[F_SKIP]  = skip_q;
                            wr_data.lo[F_RD]    = rd_q;
                        end
                        OP_DELETE: wr_en = slot_same;
                        default: begin
                            fin_hit    = slot_same;
                            fin_status = slot_same ? ST_HIT : ST_MISS;
                        end
                    endcase
                end else if (hop_q == LAST_HOP) begin
                    state_d = S_IDLE;
                    finish  = 1'b1;
                    if (op_q == OP_INSERT)      fin_status = ST_FULL;
                    else if (op_q == OP_LOOKUP) fin_status = ST_MISS;
                end else begin
                    state_d = S_READ;
                    step    = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_CLEAR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q        <= OP_LOOKUP;
            from_frm_q  <= 1'b0;
            clear_cmd_q <= 1'b0;
            key_q       <= '0;
            skip_q      <= 1'b0;
            rd_q        <= 1'b0;
            idx_q       <= '0;
            sweep_q     <= '0;
            hop_q       <= '0;
        end else if (take_cmd || take_frm) begin
            op_q        <= take_cmd ? mhf_op_e'(cmd_op) : OP_LOOKUP;
            from_frm_q  <= take_frm;
            clear_cmd_q <= take_cmd && (mhf_op_e'(cmd_op) == OP_CLEAR);
            key_q       <= in_key;
            skip_q      <= cmd_skip;
            rd_q        <= cmd_rd;
            idx_q       <= in_slot;
            sweep_q     <= '0;
            hop_q       <= '0;
        end else if (state_q == S_CLEAR) begin
            sweep_q <= sweep_q + 1'b1;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
            hop_q <= hop_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_done     <= 1'b0;
            cmd_status   <= ST_OK;
            cmd_hit_skip <= 1'b0;
            cmd_hit_rd   <= 1'b0;
            frm_done     <= 1'b0;
            frm_hit      <= 1'b0;
            frm_skip     <= 1'b0;
            frm_rd       <= 1'b0;
        end else begin
            cmd_done <= finish && !from_frm_q;
            frm_done <= finish && from_frm_q;
            if (finish && !from_frm_q) begin
                cmd_status   <= fin_status;
                cmd_hit_skip <= fin_hit && cur.lo[F_SKIP];
                cmd_hit_rd   <= fin_hit && cur.lo[F_RD];
            end
            if (finish && from_frm_q) begin
                frm_hit  <= fin_hit;
                frm_skip <= fin_hit && cur.lo[F_SKIP];
                frm_rd   <= fin_hit && cur.lo[F_RD];
            end
        end
    end
endmodule

// File: rtl/mac_hash_filter_chk.sv
module mac_hash_filter_chk #(
    parameter int HOPS = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             frm_ready,
    input logic             cmd_done,
    input logic [1:0]       cmd_status,
    input logic             frm_done,
    input logic             frm_hit,
    input logic             frm_skip,
    input logic             frm_rd,
    input logic [1:0]       op_q,
    input logic [$clog2(HOPS+1)-1:0] hop_q
);
    a_r10_done_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && frm_done));

    a_r8_command_first: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !frm_ready);

    a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r5_full_from_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && cmd_status == 2'd1) |-> (op_q == 2'd0));

    a_r6_delete_always_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && op_q == 2'd1) |-> (cmd_status == 2'd0));

    a_r7_miss_flags_low: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !frm_hit) |-> (!frm_skip && !frm_rd));

    a_r3_hop_in_budget: assert property (@(posedge clk) disable iff (!rst_n)
        hop_q < ($clog2(HOPS+1))'(HOPS));
endmodule

bind mac_hash_filter mac_hash_filter_chk #(.HOPS(HOPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .frm_ready  (frm_ready),
    .cmd_done   (cmd_done),
    .cmd_status (cmd_status),
    .frm_done   (frm_done),
    .frm_hit    (frm_hit),
    .frm_skip   (frm_skip),
    .frm_rd     (frm_rd),
    .op_q       (op_q),
    .hop_q      (hop_q)
);

// File: tb/mac_hash_filter_test.sv
`timescale 1ns/1ps
module mac_hash_filter_test;
    localparam int HOPS  = 12;
    localparam int NSLOT = 2048;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        cmd_valid, cmd_ready, cmd_skip, cmd_rd, cmd_done;
    logic [1:0]  cmd_op, cmd_status;
    logic [47:0] cmd_mac, frm_mac;
    logic        cmd_hit_skip, cmd_hit_rd;
    logic        frm_valid, frm_ready, frm_done, frm_hit, frm_skip, frm_rd;

    mac_hash_filter #(.HOPS(HOPS)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_mac(cmd_mac), .cmd_skip(cmd_skip), .cmd_rd(cmd_rd),
        .cmd_done(cmd_done), .cmd_status(cmd_status),
        .cmd_hit_skip(cmd_hit_skip), .cmd_hit_rd(cmd_hit_rd),
        .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_mac(frm_mac),
        .frm_done(frm_done), .frm_hit(frm_hit), .frm_skip(frm_skip), .frm_rd(frm_rd)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit cmd_wait = 0, frm_wait = 0;
    time t_cmd_done, t_frm_take;

    bit          mv [NSLOT];
    logic [47:0] mm [NSLOT];
    bit          ms [NSLOT];
    bit          mr [NSLOT];

    logic [47:0] grp [13];
    logic [47:0] wrp [3];

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] ref_slot(input logic [47:0] m);
        logic [47:0] r;
        logic [15:0] h;
        logic [31:0] l;
        logic [8:0]  x;
        for (int b = 0; b < 6; b++)
            for (int k = 0; k < 8; k++)
                r[b*8+k] = m[b*8+7-k];
        h = r[47:32];
        l = r[31:0];
        x = {l[14:8], l[1:0]} ^ l[23:15] ^ {h[0], l[31:24]};
        return {l[3:2], x};
    endfunction

    function automatic logic [47:0] find_mac(input logic [10:0] target,
                                             input logic [47:0] base, input int nth);
        int n = 0;
        for (int i = 0; i < 400000; i++) begin
            logic [47:0] m;
            m = base + 48'(i);
            if (ref_slot(m) == target) begin
                if (n == nth) return m;
                n++;
            end
        end
        return base;
    endfunction

    task automatic model_op(input logic [1:0] op, input logic [47:0] mac,
                            input bit s, input bit r, output int p,
                            output logic [1:0] st, output bit hs, output bit hr);
        int start;
        bit stop = 0;
        p = 0; st = 2'd0; hs = 0; hr = 0;
        if (op == 2'd3) begin
            for (int i = 0; i < NSLOT; i++) mv[i] = 0;
            return;
        end
        start = int'(ref_slot(mac));
        for (int h = 0; h < HOPS && !stop; h++) begin
            int i;
            i = (start + h) % NSLOT;
            p = h + 1;
            if (!mv[i] || mm[i] == mac) begin
                stop = 1;
                if (op == 2'd0) begin
                    mv[i] = 1; mm[i] = mac; ms[i] = s; mr[i] = r;
                end else if (op == 2'd1) begin
                    mv[i] = 0;
                end else if (mv[i]) begin
                    st = 2'd2; hs = ms[i]; hr = mr[i];
                end else begin
                    st = 2'd3;
                end
            end
        end
        if (!stop) begin
            if (op == 2'd0)      st = 2'd1;
            else if (op == 2'd2) st = 2'd3;
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [47:0] mac,
                          input bit s, input bit r, input string req);
        int p, k, exp_k;
        logic [1:0] st;
        bit hs, hr;
        model_op(op, mac, s, r, p, st, hs, hr);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_mac = mac; cmd_skip = s; cmd_rd = r;
        cmd_valid = 1; cmd_wait = 1;
        @(negedge clk);
        cmd_valid = 0;
        k = 1;
        while (!cmd_done && k < 5000) begin @(negedge clk); k++; end
        t_cmd_done = $time;
        exp_k = (op == 2'd3) ? NSLOT + 1 : 2 * p + 1;
        check_eq(req, "R10 latency", k, exp_k);
        check_eq(req, "status", cmd_status, st);
        if (op == 2'd2) begin
            check_eq(req, "hit skip", cmd_hit_skip, hs);
            check_eq(req, "hit rd", cmd_hit_rd, hr);
        end
        @(negedge clk);
        cmd_wait = 0;
    endtask

    task automatic do_frm(input logic [47:0] mac, input string req);
        int p, k;
        logic [1:0] st;
        bit hs, hr;
        model_op(2'd2, mac, 0, 0, p, st, hs, hr);
        frm_mac = mac; frm_valid = 1; frm_wait = 1;
        #1;
        while (!frm_ready) begin @(negedge clk); #1; end
        t_frm_take = $time;
        @(negedge clk);
        frm_valid = 0;
        k = 1;
        while (!frm_done && k < 5000) begin @(negedge clk); k++; end
        check_eq(req, "R10 frame latency", k, 2 * p + 1);
        check_eq(req, "frame hit", frm_hit, st == 2'd2);
        check_eq(req, "frame skip", frm_skip, hs);
        check_eq(req, "frame rd", frm_rd, hr);
        @(negedge clk);
        frm_wait = 0;
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && cmd_done && !cmd_wait) begin
            total++; bad++;
            $display("FAIL R10 spurious cmd_done: actual=1 expected=0");
        end
        if (rst_n && frm_done && !frm_wait) begin
            total++; bad++;
            $display("FAIL R10 spurious frm_done: actual=1 expected=0");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k;
        logic [47:0] addr_a;
        rst_n = 0; cmd_valid = 0; frm_valid = 0;
        cmd_op = 0; cmd_mac = 0; cmd_skip = 0; cmd_rd = 0; frm_mac = 0;
        for (int i = 0; i < NSLOT; i++) mv[i] = 0;
        addr_a = 48'h02_1A_3C_4D_5E_6F;
        for (int n = 0; n < 13; n++) grp[n] = find_mac(ref_slot(48'h0A_0B_0C_0D_0E_0F), 48'h0A_0B_0C_0D_0E_0F, n);
        for (int n = 0; n < 3; n++)  wrp[n] = find_mac(11'h7FF, 48'h00_11_22_33_44_55, n);

        repeat (3) @(negedge clk);
        check_eq("R1", "cmd_ready in reset", cmd_ready, 0);
        check_eq("R1", "frm_ready in reset", frm_ready, 0);
        rst_n = 1;
        k = 0;
        while (!cmd_ready && k < 5000) begin @(negedge clk); k++; end
        check_eq("R1", "sweep cycles", k, NSLOT);

        do_cmd(2'd2, addr_a, 0, 0, "R7");
        do_cmd(2'd0, addr_a, 1, 0, "R4");
        do_cmd(2'd2, addr_a, 0, 0, "R7");

        for (int n = 0; n < 12; n++) do_cmd(2'd0, grp[n], 0, 0, "R2");
        do_cmd(2'd0, grp[12], 1, 1, "R5");
        do_cmd(2'd2, grp[12], 0, 0, "R5");
        do_frm(grp[11], "R3");

        do_cmd(2'd0, grp[3], 0, 1, "R4");
        do_frm(grp[3], "R8");

        do_cmd(2'd1, 48'hDE_AD_BE_EF_00_01, 0, 0, "R6");
        do_frm(grp[5], "R6");
        do_cmd(2'd1, grp[0], 0, 0, "R6");
        do_cmd(2'd2, grp[0], 0, 0, "R6");
        do_cmd(2'd2, grp[1], 0, 0, "R6");

        for (int n = 0; n < 3; n++) do_cmd(2'd0, wrp[n], n[0], 1, "R3");
        do_frm(wrp[2], "R3");

        fork
            do_cmd(2'd2, addr_a, 0, 0, "R8");
            do_frm(wrp[0], "R8");
        join
        check_eq("R8", "frame taken after command", t_frm_take > t_cmd_done, 1);

        do_cmd(2'd3, 48'h0, 0, 0, "R9");
        do_cmd(2'd2, grp[3], 0, 0, "R9");
        do_frm(addr_a, "R9");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule